// File: doc/BRIEF.md
# Hall Commutation Decoder with Direction Control

This block turns three digitised rotor-position bits into the six gate commands of a three-phase bridge. Each valid position code selects one sector. In that sector exactly one high-side switch and one low-side switch of two different phases are on. A direction input picks the forward or the reverse sequence. In reverse, the sector is looked up with the complement of the position code.

Chopping is applied only to the high-side commands. A PWM gate input masks them, and so do the undervoltage flag and the off phase of an external lock timer. The low-side command of the sector stays solidly on through all three. The two all-equal position codes are not valid sector codes, so they blank all six outputs. When the direction input changes, one clock of all-off dead time is inserted before the new sector appears.

A speed-sense pulse output either repeats the first position bit or carries the parity of all three bits. Parity toggles on every position edge. The position bits pass through a synchroniser before decoding. Every output is registered.

Top module: `hall_commutator`

## Requirements
- R1: With `fwd_rev`=0, position code {hall_in[2],hall_in[1],hall_in[0]} gives these outputs: 101 gives hs_v+ls_u, 100 gives hs_w+ls_u, 110 gives hs_w+ls_v, 010 gives hs_u+ls_v, 011 gives hs_u+ls_w, and 001 gives hs_v+ls_w.
- R2: With `fwd_rev`=1, the outputs are those that R1 gives for the bitwise complement of the code (for example 010 gives hs_v+ls_u).
- R3: While `pwm_gate`=0, all high-side outputs are low and the low-side output of the sector is unchanged.
- R4: Codes 000 and 111 drive all six gate outputs low.
- R5: While `uv_fault`=1, all high-side outputs are low and the low-side output stays on. The flag is taken as already carrying its clear-threshold hysteresis.
- R6: While `lock_off`=1, all high-side outputs are low and the low-side output stays on.
- R7: A clock edge at which `fwd_rev` differs from its value at the previous edge drives all six outputs low for that one cycle. The next edge drives the sector of the new direction.
- R8: `hp_out` equals hall_in[2] when `hp_combine`=0, and the XOR of the three bits when `hp_combine`=1.
- R9: A change of `hall_in` reaches the outputs at the third rising edge: two synchroniser stages and one output register. A change of `fwd_rev`, `pwm_gate`, `uv_fault`, `lock_off` or `hp_combine` reaches the outputs at the next rising edge.
- R10: While `rst_n` is low, all gate outputs and `hp_out` are low.
- R11: At most one high-side output and at most one low-side output are high at any time, and never both switches of one phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hall_in | input | 3 | Position bits; bit 2 is sensor 1 |
| fwd_rev | input | 1 | 0 forward, 1 reverse |
| pwm_gate | input | 1 | 1 lets the high-side command through |
| uv_fault | input | 1 | Undervoltage flag, blanks high side |
| lock_off | input | 1 | Lock-timer off phase, blanks high side |
| hp_combine | input | 1 | 0: single-sensor pulse, 1: parity of all sensors |
| hs_u | output | 1 | High-side gate, phase U |
| hs_v | output | 1 | High-side gate, phase V |
| hs_w | output | 1 | High-side gate, phase W |
| ls_u | output | 1 | Low-side gate, phase U |
| ls_v | output | 1 | Low-side gate, phase V |
| ls_w | output | 1 | Low-side gate, phase W |
| hp_out | output | 1 | Speed-sense pulse |

## Verification
The bench drives the two all-equal codes. A decoder that treated them as sectors would leave a switch pair on while the rotor position is unknown. It flips the direction input in the middle of a sector. A design without the dead cycle would move straight from one bridge pair to another, which is the shoot-through path. It holds the PWM, undervoltage and lock inputs low and high in every sector. A design that gated the low side as well would lose the current path. Directed steps also count edges from a position change to the output, which exposes a missing or extra synchroniser stage.

// File: rtl/hc_pkg.sv
package hc_pkg;
  localparam int PHASES = 3;
  typedef logic [PHASES-1:0] phase_t;
  localparam phase_t PH_NONE = 3'b000;
  localparam phase_t PH_U    = 3'b001;
  localparam phase_t PH_V    = 3'b010;
  localparam phase_t PH_W    = 3'b100;
  typedef struct packed {
    phase_t hi;
    phase_t lo;
  } gate_pair_t;
  localparam gate_pair_t PAIR_OFF = '{hi: PH_NONE, lo: PH_NONE};
endpackage

// File: rtl/hc_sync.sv
module hc_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hc_sector.sv
module hc_sector
  import hc_pkg::*;
(
  input  logic [2:0] code,
  input  logic       rev,
  output gate_pair_t pair
);
  logic [2:0] key;

  assign key = rev ? ~code : code;

  always_comb begin
    pair = PAIR_OFF;
    unique case (key)
      3'b100: pair = '{hi: PH_W, lo: PH_U};
      3'b101: pair = '{hi: PH_V, lo: PH_U};
      3'b001: pair = '{hi: PH_V, lo: PH_W};
      3'b011: pair = '{hi: PH_U, lo: PH_W};
      3'b010: pair = '{hi: PH_U, lo: PH_V};
      3'b110: pair = '{hi: PH_W, lo: PH_V};
      default: pair = PAIR_OFF;
    endcase
  end
endmodule

// File: rtl/hc_gate.sv
module hc_gate
  import hc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  gate_pair_t sector,
  input  logic       rev,
  input  logic       pwm_gate,
  input  logic       uv_fault,
  input  logic       lock_off,
  output phase_t     hi_q,
  output phase_t     lo_q
);
  logic   rev_q;
  logic   turning;
  logic   hi_allow;
  phase_t hi_d;
  phase_t lo_d;

  assign turning  = (rev != rev_q);
  assign hi_allow = pwm_gate & ~uv_fault & ~lock_off;

  always_comb begin
    if (turning) begin
      hi_d = PH_NONE;
      lo_d = PH_NONE;
    end else begin
      hi_d = hi_allow ? sector.hi : PH_NONE;
      lo_d = sector.lo;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rev_q <= 1'b0;
      hi_q  <= PH_NONE;
      lo_q  <= PH_NONE;
    end else begin
      rev_q <= rev;
      hi_q  <= hi_d;
      lo_q  <= lo_d;
    end
  end

  AST_HI_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hi_q)); // R11
  AST_LO_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lo_q)); // R11
  AST_NO_LEG_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_q & lo_q) == PH_NONE); // R11
  AST_PWM_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_gate |=> hi_q == PH_NONE); // R3
  AST_UV_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    uv_fault |=> hi_q == PH_NONE); // R5
  AST_LOCK_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    lock_off |=> hi_q == PH_NONE); // R6
  AST_DIR_DEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (rev != rev_q) |=> (hi_q == PH_NONE && lo_q == PH_NONE)); // R7
endmodule

// File: rtl/hc_pulse.sv
module hc_pulse (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] code,
  input  logic       combine,
  output logic       pulse_q
);
  logic pulse_d;

  assign pulse_d = combine ? (code[0] ^ code[1] ^ code[2]) : code[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= pulse_d;
  end

  AST_HP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!combine && code[2]) |=> pulse_q); // R8
endmodule

// File: rtl/hall_commutator.sv
module hall_commutator
  import hc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] hall_in,
  input  logic       fwd_rev,
  input  logic       pwm_gate,
  input  logic       uv_fault,
  input  logic       lock_off,
  input  logic       hp_combine,
  output logic       hs_u,
  output logic       hs_v,
  output logic       hs_w,
  output logic       ls_u,
  output logic       ls_v,
  output logic       ls_w,
  output logic       hp_out
);
  logic [2:0] hall_s;
  gate_pair_t sector;
  phase_t     hi_q;
  phase_t     lo_q;

  hc_sync #(.WIDTH(PHASES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(hall_in), .q(hall_s)
  );

  hc_sector u_sector (
    .code(hall_s), .rev(fwd_rev), .pair(sector)
  );

  hc_gate u_gate (
    .clk(clk), .rst_n(rst_n), .sector(sector), .rev(fwd_rev),
    .pwm_gate(pwm_gate), .uv_fault(uv_fault), .lock_off(lock_off),
    .hi_q(hi_q), .lo_q(lo_q)
  );

  hc_pulse u_pulse (
    .clk(clk), .rst_n(rst_n), .code(hall_s), .combine(hp_combine),
    .pulse_q(hp_out)
  );

  assign {hs_w, hs_v, hs_u} = hi_q;
  assign {ls_w, ls_v, ls_u} = lo_q;

  AST_EQUAL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (hall_s == 3'b000 || hall_s == 3'b111) |=>
      ({hs_u, hs_v, hs_w, ls_u, ls_v, ls_w} == 6'b0)); // R4
  AST_SECTOR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (hall_s != 3'b000 && hall_s != 3'b111 && fwd_rev == $past(fwd_rev)) |=>
      $countones({ls_u, ls_v, ls_w}) == 1); // R3
endmodule

// File: tb/hall_commutator_test.sv
module hall_commutator_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] hall_in = 3'b000;
  logic       fwd_rev = 1'b0;
  logic       pwm_gate = 1'b0;
  logic       uv_fault = 1'b0;
  logic       lock_off = 1'b0;
  logic       hp_combine = 1'b0;
  logic       hs_u, hs_v, hs_w, ls_u, ls_v, ls_w, hp_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  hall_commutator uut (
    .clk(clk), .rst_n(rst_n), .hall_in(hall_in), .fwd_rev(fwd_rev),
    .pwm_gate(pwm_gate), .uv_fault(uv_fault), .lock_off(lock_off),
    .hp_combine(hp_combine), .hs_u(hs_u), .hs_v(hs_v), .hs_w(hs_w),
    .ls_u(ls_u), .ls_v(ls_v), .ls_w(ls_w), .hp_out(hp_out)
  );

  // packing: [5:3] high side W,V,U ; [2:0] low side W,V,U
  function automatic logic [5:0] ref_sector(logic [2:0] h, logic d);
    logic [2:0] c;
    c = d ? ~h : h;
    case (c)
      3'b101: return 6'b010_001;
      3'b100: return 6'b100_001;
      3'b110: return 6'b100_010;
      3'b010: return 6'b001_010;
      3'b011: return 6'b001_100;
      3'b001: return 6'b010_100;
      default: return 6'b000_000;
    endcase
  endfunction

  function automatic logic [31:0] pick_tag(logic [2:0] h, logic d, logic dprev,
                                           logic p, logic u, logic l);
    if (d != dprev) return "R7";
    if (h == 3'b000 || h == 3'b111) return "R4";
    if (u) return "R5";
    if (l) return "R6";
    if (!p) return "R3";
    if (d) return "R2";
    return "R1";
  endfunction

  // reference pipeline derived from R9 latencies
  logic [2:0]  m_h1, m_h2;
  logic        m_dir;
  logic [5:0]  e_pair;
  logic        e_hp;
  logic [31:0] e_tag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_h1 <= '0; m_h2 <= '0; m_dir <= 1'b0;
      e_pair <= '0; e_hp <= 1'b0; e_tag <= "R10";
    end else begin
      logic [5:0] s;
      s = ref_sector(m_h2, fwd_rev);
      if (fwd_rev != m_dir) s = 6'b0;
      if (!pwm_gate || uv_fault || lock_off) s[5:3] = 3'b0;
      m_h1 <= hall_in;
      m_h2 <= m_h1;
      m_dir <= fwd_rev;
      e_pair <= s;
      e_hp <= hp_combine ? ^m_h2 : m_h2[2];
      e_tag <= pick_tag(m_h2, fwd_rev, m_dir, pwm_gate, uv_fault, lock_off);
    end
  end

  function automatic logic [5:0] got_pair();
    return {hs_w, hs_v, hs_u, ls_w, ls_v, ls_u};
  endfunction

  task automatic chk(input logic [31:0] tag, input logic [5:0] got, input logic [5:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %0s got=%b exp=%b at %0t", tag, got, exp, $time);
    end
  endtask

  // sampled at negedge, away from the active edge
  task automatic step_check();
    @(negedge clk);
    chk(e_tag, got_pair(), e_pair);
    chk("R8", {5'b0, hp_out}, {5'b0, e_hp});
    chk("R11", {4'b0, ($countones({hs_u,hs_v,hs_w}) > 1), ($countones({ls_u,ls_v,ls_w}) > 1)}, 6'b0);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    // R10: reset state
    repeat (3) @(negedge clk);
    chk("R10", got_pair(), 6'b0);
    chk("R10", {5'b0, hp_out}, 6'b0);
    rst_n = 1'b1;
    pwm_gate = 1'b1;

    // R9: hall latency of three edges
    step_check();
    hall_in = 3'b101;
    @(negedge clk); chk("R9", got_pair(), 6'b0);
    @(negedge clk); chk("R9", got_pair(), 6'b0);
    @(negedge clk); chk("R9", got_pair(), 6'b010_001);
    // R9: pwm latency of one edge
    pwm_gate = 1'b0;
    @(negedge clk); chk("R9", got_pair(), 6'b000_001);
    pwm_gate = 1'b1;
    @(negedge clk); chk("R1", got_pair(), 6'b010_001);

    // R1 and R2: walk every code in both directions
    for (int d = 0; d < 2; d++) begin
      fwd_rev = d[0];
      for (int c = 0; c < 8; c++) begin
        hall_in = c[2:0];
        repeat (4) step_check();
        chk(d ? "R2" : "R1", got_pair(), ref_sector(c[2:0], d[0]));
      end
    end

    // R7: direction flip inside a sector
    fwd_rev = 1'b0; hall_in = 3'b110;
    repeat (4) step_check();
    fwd_rev = 1'b1;
    @(negedge clk); chk("R7", got_pair(), 6'b0);
    @(negedge clk); chk("R7", got_pair(), ref_sector(3'b110, 1'b1));

    // R5, R6: protection keeps low side
    uv_fault = 1'b1;
    @(negedge clk); chk("R5", got_pair(), {3'b0, ref_sector(3'b110, 1'b1)} & 6'b000_111);
    uv_fault = 1'b0; lock_off = 1'b1;
    @(negedge clk); chk("R6", got_pair(), ref_sector(3'b110, 1'b1) & 6'b000_111);
    lock_off = 1'b0;

    // R8: both pulse modes
    hp_combine = 1'b1; hall_in = 3'b011;
    repeat (3) step_check();
    chk("R8", {5'b0, hp_out}, 6'b0);
    hp_combine = 1'b0;
    @(negedge clk); chk("R8", {5'b0, hp_out}, 6'b0);
    hall_in = 3'b100;
    repeat (3) step_check();
    chk("R8", {5'b0, hp_out}, 6'b000_001);

    // constrained random run
    for (int i = 0; i < 4000; i++) begin
      hall_in = ($urandom % 10 == 0) ? (($urandom % 2) ? 3'b111 : 3'b000)
                                      : 3'($urandom);
      if ($urandom % 40 == 0) fwd_rev = ~fwd_rev;
      pwm_gate   = ($urandom % 4) != 0;
      uv_fault   = ($urandom % 25) == 0;
      lock_off   = ($urandom % 25) == 0;
      if ($urandom % 30 == 0) hp_combine = ~hp_combine;
      step_check();
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule